// File: doc/BRIEF.md
# Shared Traffic Memory Word Access Arbiter

This block gives a bus-side controller and a host CPU turns at one single-port traffic memory. Each requester asks for a block transfer by giving a base address, a word count, a direction and write data. An arbiter picks one requester. A sequencer then moves through the block one word at a time, and a per-word state machine drives the memory strobe, waits out a programmable settle time and then waits for the memory's ready handshake.

The requester that holds the grant gets one ready pulse per word. On a read, the word is on the shared read-data output during that pulse. On a write, the requester moves to its next write word after each pulse. A done pulse marks the last word and frees the memory. A requester that asks while the other one holds the grant keeps its request raised and is served next.

Top module: `tm_word_arbiter`

## Requirements
- R1: The grant outputs `bus_gnt` and `cpu_gnt` are never high in the same cycle. A grant rises in the cycle after the arbiter, while free, sees a request.
- R2: If both requests are high while the arbiter is free, the grant goes to the side that was not served last. After reset the bus side wins the first such tie. A lone request is granted to its own side.
- R3: Each word takes this sequence of cycles:
  - one idle cycle;
  - one launch cycle;
  - a settle phase of `wait_cfg`+1 cycles;
  - a handshake phase that lasts until `mem_ready` is sampled high;
  - one deliver cycle.
  `mem_stb` is high from the launch cycle through the handshake cycle in which ready is seen, and low otherwise.
- R4: `wait_cfg` is sampled when the grant is taken. Changing it during a transfer has no effect on that transfer's strobe timing.
- R5: During the strobe of word i (i counted from 0), `mem_addr` equals the latched base address plus i, modulo 2^AW. `mem_addr` does not change while the strobe stays high.
- R6: For a write (`*_we`=1), `mem_we` is high with the strobe and `mem_wdata` carries the granted side's write data. For a read, `mem_we` is low, and in the deliver cycle `rd_data` shows the `mem_rdata` value sampled in the cycle ready was seen.
- R7: The length field holds the word count minus one, so 0 means one word and 15 means sixteen words. The done output of the granted side pulses together with its ready pulse on the last word. Its grant is low in the cycle that follows.
- R8: The grant is held for the whole block. The other side's ready and done stay low during that time, and its raised request is served once the block ends.
- R9: The granted side gets exactly one ready pulse per word, in the deliver cycle.
- R10: During reset all grant, strobe, ready and done outputs are low and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_cfg | input | WW | Settle cycles minus one, sampled at grant |
| bus_req | input | 1 | Bus side transfer request, held until its done |
| bus_we | input | 1 | Bus side direction, 1 = write |
| bus_base | input | AW | Bus side block base address |
| bus_len | input | LW | Bus side word count minus one |
| bus_wdata | input | DW | Bus side write data for the current word |
| bus_gnt | output | 1 | Bus side owns the memory |
| bus_rdy | output | 1 | Bus side word completed |
| bus_done | output | 1 | Bus side block completed |
| cpu_req | input | 1 | CPU transfer request, held until its done |
| cpu_we | input | 1 | CPU direction, 1 = write |
| cpu_base | input | AW | CPU block base address |
| cpu_len | input | LW | CPU word count minus one |
| cpu_wdata | input | DW | CPU write data for the current word |
| cpu_gnt | output | 1 | CPU owns the memory |
| cpu_rdy | output | 1 | CPU word completed |
| cpu_done | output | 1 | CPU block completed |
| rd_data | output | DW | Read word, valid with the ready pulse |
| mem_stb | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| mem_ready | input | 1 | Memory handshake, honoured during the handshake phase |

## Verification
The assertions take four things as given:
- A requester keeps its request, base, length and direction steady from the cycle it raises the request until it sees its done pulse.
- The write data for a word stays put until that word's ready pulse.
- `mem_ready` is only meaningful while the strobe is high.
- `wait_cfg` may move at any time.

The bench's requester agents raise a request only when they hold a queued job. They keep every field fixed until done, and step the write word only on their own ready pulse. The memory model raises ready only after the strobe has been high for a set number of cycles. Each grant is checked against a model that runs alongside the design. Timing across ties, stalls, a `wait_cfg` change in mid-transfer, address wrap and the longest block is checked in the same way.

// File: rtl/tm_arb_pkg.sv
package tm_arb_pkg;

    localparam int unsigned NUM_SIDES = 2;

    // Phases of one word access
    typedef enum logic [2:0] {
        WS_IDLE      = 3'd0,
        WS_LAUNCH    = 3'd1,
        WS_SETTLE    = 3'd2,
        WS_HANDSHAKE = 3'd3,
        WS_DELIVER   = 3'd4
    } word_st_e;

endpackage

// File: rtl/tm_rr_arb.sv
module tm_rr_arb
    import tm_arb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SIDES-1:0] req_i,
    input  logic                 release_i,
    output logic                 take_o,
    output logic                 pick_o,
    output logic                 busy_o,
    output logic                 owner_o,
    output logic [NUM_SIDES-1:0] gnt_o
);

    typedef struct packed {
        logic busy;
        logic owner;
        logic last;
    } arb_s;

    arb_s arb_q, arb_d;

    always_comb begin
        arb_d  = arb_q;
        take_o = !arb_q.busy && (req_i != '0);
        if (&req_i) begin
            pick_o = ~arb_q.last;
        end else begin
            pick_o = req_i[1];
        end
        if (take_o) begin
            arb_d.busy  = 1'b1;
            arb_d.owner = pick_o;
        end else if (arb_q.busy && release_i) begin
            arb_d.busy = 1'b0;
            arb_d.last = arb_q.owner;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arb_q.busy  <= 1'b0;
            arb_q.owner <= 1'b0;
            arb_q.last  <= 1'b1;
        end else begin
            arb_q <= arb_d;
        end
    end

    assign busy_o  = arb_q.busy;
    assign owner_o = arb_q.owner;

    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_gnt
        assign gnt_o[g] = arb_q.busy && (arb_q.owner == 1'(g));
    end

    // R8
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_q.busy && !release_i) |=> (arb_q.busy && $stable(arb_q.owner)));

    // R2
    tie_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!arb_q.busy && (&req_i)) |=> (arb_q.owner != $past(arb_q.last)));

endmodule

// File: rtl/tm_word_fsm.sv
module tm_word_fsm
    import tm_arb_pkg::*;
#(
    parameter int WW = 3,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic [WW-1:0] wait_i,
    input  logic          mem_ready_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          stb_o,
    output logic          word_done_o,
    output logic [DW-1:0] rdata_o
);

    typedef struct packed {
        word_st_e      st;
        logic [WW-1:0] wcnt;
        logic [DW-1:0] rdata;
    } fsm_s;

    fsm_s fsm_q, fsm_d;

    always_comb begin
        fsm_d = fsm_q;
        case (fsm_q.st)
            WS_IDLE: begin
                if (go_i) fsm_d.st = WS_LAUNCH;
            end
            WS_LAUNCH: begin
                fsm_d.st   = WS_SETTLE;
                fsm_d.wcnt = '0;
            end
            WS_SETTLE: begin
                if (fsm_q.wcnt == wait_i) begin
                    fsm_d.st = WS_HANDSHAKE;
                end else begin
                    fsm_d.wcnt = fsm_q.wcnt + 1'b1;
                end
            end
            WS_HANDSHAKE: begin
                if (mem_ready_i) begin
                    fsm_d.st    = WS_DELIVER;
                    fsm_d.rdata = mem_rdata_i;
                end
            end
            WS_DELIVER: begin
                fsm_d.st = WS_IDLE;
            end
            default: begin
                fsm_d.st = WS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.st    <= WS_IDLE;
            fsm_q.wcnt  <= '0;
            fsm_q.rdata <= '0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign stb_o       = (fsm_q.st == WS_LAUNCH) || (fsm_q.st == WS_SETTLE) ||
                         (fsm_q.st == WS_HANDSHAKE);
    assign word_done_o = (fsm_q.st == WS_DELIVER);
    assign rdata_o     = fsm_q.rdata;

    // R3
    launch_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == WS_LAUNCH) |=> (fsm_q.st == WS_SETTLE));

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fsm_q.st == WS_HANDSHAKE) && !mem_ready_i) |=> ((fsm_q.st == WS_HANDSHAKE) && stb_o));

    // R3
    single_deliver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_done_o |=> !word_done_o);

    // R6
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fsm_q.st == WS_HANDSHAKE) && mem_ready_i) |=> (rdata_o == $past(mem_rdata_i)));

endmodule

// File: rtl/tm_blk_seq.sv
module tm_blk_seq #(
    parameter int AW = 8,
    parameter int LW = 4,
    parameter int WW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_i,
    input  logic [AW-1:0] base_i,
    input  logic [LW-1:0] len_i,
    input  logic          we_i,
    input  logic [WW-1:0] wait_i,
    input  logic          word_done_i,
    output logic [AW-1:0] addr_o,
    output logic          we_o,
    output logic [WW-1:0] wait_o,
    output logic          last_o,
    output logic          done_o
);

    typedef struct packed {
        logic [AW-1:0] base;
        logic [LW-1:0] len;
        logic          we;
        logic [WW-1:0] wait_n;
        logic [LW-1:0] cnt;
    } seq_s;

    seq_s seq_q, seq_d;

    always_comb begin
        seq_d = seq_q;
        if (take_i) begin
            seq_d.base   = base_i;
            seq_d.len    = len_i;
            seq_d.we     = we_i;
            seq_d.wait_n = wait_i;
            seq_d.cnt    = '0;
        end else if (word_done_i) begin
            if (seq_q.cnt == seq_q.len) begin
                seq_d.cnt = '0;
            end else begin
                seq_d.cnt = seq_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign addr_o = seq_q.base + AW'(seq_q.cnt);
    assign we_o   = seq_q.we;
    assign wait_o = seq_q.wait_n;
    assign last_o = (seq_q.cnt == seq_q.len);
    assign done_o = word_done_i && last_o;

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done_i && !last_o && !take_i) |=> (seq_q.cnt == LW'($past(seq_q.cnt) + 1'b1)));

    // R7
    count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (seq_q.cnt == '0));

endmodule

// File: rtl/tm_word_arbiter.sv
module tm_word_arbiter
    import tm_arb_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16,
    parameter int LW = 4,
    parameter int WW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [WW-1:0] wait_cfg,
    input  logic          bus_req,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_base,
    input  logic [LW-1:0] bus_len,
    input  logic [DW-1:0] bus_wdata,
    output logic          bus_gnt,
    output logic          bus_rdy,
    output logic          bus_done,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_base,
    input  logic [LW-1:0] cpu_len,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_gnt,
    output logic          cpu_rdy,
    output logic          cpu_done,
    output logic [DW-1:0] rd_data,
    output logic          mem_stb,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready
);

    logic [NUM_SIDES-1:0] req_v, gnt_v, rdy_v, done_v;
    logic                 take, pick, busy, owner;
    logic                 word_done, blk_done, blk_last, seq_we;
    logic [WW-1:0]        seq_wait;
    logic                 stb;

    assign req_v = {cpu_req, bus_req};

    tm_rr_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_v),
        .release_i (blk_done),
        .take_o    (take),
        .pick_o    (pick),
        .busy_o    (busy),
        .owner_o   (owner),
        .gnt_o     (gnt_v)
    );

    tm_blk_seq #(.AW(AW), .LW(LW), .WW(WW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_i      (take),
        .base_i      (pick ? cpu_base : bus_base),
        .len_i       (pick ? cpu_len : bus_len),
        .we_i        (pick ? cpu_we : bus_we),
        .wait_i      (wait_cfg),
        .word_done_i (word_done),
        .addr_o      (mem_addr),
        .we_o        (seq_we),
        .wait_o      (seq_wait),
        .last_o      (blk_last),
        .done_o      (blk_done)
    );

    tm_word_fsm #(.WW(WW), .DW(DW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_i        (busy),
        .wait_i      (seq_wait),
        .mem_ready_i (mem_ready),
        .mem_rdata_i (mem_rdata),
        .stb_o       (stb),
        .word_done_o (word_done),
        .rdata_o     (rd_data)
    );

    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
        assign rdy_v[g]  = word_done && busy && (owner == 1'(g));
        assign done_v[g] = rdy_v[g] && blk_last;
    end

    assign mem_stb   = stb;
    assign mem_we    = stb && seq_we;
    assign mem_wdata = owner ? cpu_wdata : bus_wdata;

    assign bus_gnt  = gnt_v[0];
    assign cpu_gnt  = gnt_v[1];
    assign bus_rdy  = rdy_v[0];
    assign cpu_rdy  = rdy_v[1];
    assign bus_done = done_v[0];
    assign cpu_done = done_v[1];

    // R1
    grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cpu_gnt, bus_gnt}));

    // R9
    rdy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cpu_rdy, bus_rdy}));

    // R7
    done_with_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_done || cpu_done) |-> (bus_rdy || cpu_rdy));

    // R5
    addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_stb && $past(mem_stb)) |-> $stable(mem_addr));

endmodule

// File: tb/sim_tm_word_arbiter.sv
module sim_tm_word_arbiter;

    logic        clk;
    logic        rst_n;
    logic [2:0]  wait_cfg;
    logic        bus_req, bus_we, bus_gnt, bus_rdy, bus_done;
    logic [7:0]  bus_base;
    logic [3:0]  bus_len;
    logic [15:0] bus_wdata;
    logic        cpu_req, cpu_we, cpu_gnt, cpu_rdy, cpu_done;
    logic [7:0]  cpu_base;
    logic [3:0]  cpu_len;
    logic [15:0] cpu_wdata;
    logic [15:0] rd_data;
    logic        mem_stb, mem_we, mem_ready;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata, mem_rdata;

    tm_word_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .wait_cfg(wait_cfg),
        .bus_req(bus_req), .bus_we(bus_we), .bus_base(bus_base), .bus_len(bus_len),
        .bus_wdata(bus_wdata), .bus_gnt(bus_gnt), .bus_rdy(bus_rdy), .bus_done(bus_done),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_base(cpu_base), .cpu_len(cpu_len),
        .cpu_wdata(cpu_wdata), .cpu_gnt(cpu_gnt), .cpu_rdy(cpu_rdy), .cpu_done(cpu_done),
        .rd_data(rd_data), .mem_stb(mem_stb), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Bench memory: ready after the strobe has been high for lat cycles
    logic [15:0] mem [0:255];
    int stb_cnt = 0;
    int lat = 0;
    bit prev_stb = 0;
    assign mem_rdata = mem[mem_addr];
    assign mem_ready = mem_stb && (stb_cnt >= lat);

    int n_total = 0;
    int n_fail  = 0;
    bit finished = 0;
    bit r4_zone = 0;
    int wait_next = 0;

    // Reference model state
    int m_busy = 0, m_own = 0, m_last = 1, m_base = 0, m_len = 0, m_we = 0;
    int m_wait = 0, m_idx = 0, m_t = 0, m_dv = 0;
    logic [15:0] m_rdat = '0;
    bit prev_done [2] = '{0, 0};

    // Requester agents
    int jb [2][$];
    int jl [2][$];
    int jw [2][$];
    int a_req [2] = '{0, 0};
    int a_base [2] = '{0, 0};
    int a_len [2] = '{0, 0};
    int a_we [2] = '{0, 0};
    int a_idx [2] = '{0, 0};

    function automatic logic [15:0] wpat(int s, int b, int i);
        return 16'((s * 16'h4000) ^ (b * 37) ^ (i * 16'h0101) ^ 16'h5a5a);
    endfunction

    function automatic string tg(string t);
        return rst_n ? t : "R10";
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic push(int s, int b, int l, int w);
        jb[s].push_back(b);
        jl[s].push_back(l);
        jw[s].push_back(w);
    endtask

    task automatic compare();
        bit exp_stb;
        int gv [2];
        int rv [2];
        int dv [2];
        gv[0] = bus_gnt;  gv[1] = cpu_gnt;
        rv[0] = bus_rdy;  rv[1] = cpu_rdy;
        dv[0] = bus_done; dv[1] = cpu_done;
        chk(!(bus_gnt && cpu_gnt), tg("R1"), "both grants", {bus_gnt, cpu_gnt}, 0);
        exp_stb = (m_busy != 0) && (m_dv == 0) && (m_t >= 1);
        for (int s = 0; s < 2; s++) begin
            int eg, er, ed;
            eg = (m_busy != 0 && m_own == s) ? 1 : 0;
            er = (eg != 0 && m_dv != 0) ? 1 : 0;
            ed = (er != 0 && m_idx == m_len) ? 1 : 0;
            chk(gv[s] == eg, tg("R2"), $sformatf("grant side %0d", s), gv[s], eg);
            if (prev_done[s]) chk(gv[s] == 0, tg("R7"), "grant after done", gv[s], 0);
            chk(rv[s] == er, tg((m_busy != 0 && m_own != s) ? "R8" : "R9"),
                $sformatf("ready side %0d", s), rv[s], er);
            chk(dv[s] == ed, tg("R7"), $sformatf("done side %0d", s), dv[s], ed);
        end
        chk(mem_stb == exp_stb, tg(r4_zone ? "R4" : "R3"), "strobe", mem_stb, exp_stb);
        if (exp_stb) begin
            chk(int'(mem_addr) == ((m_base + m_idx) % 256), "R5", "address",
                mem_addr, (m_base + m_idx) % 256);
            chk(mem_we == m_we[0], "R6", "write enable", mem_we, m_we);
            if (m_we != 0)
                chk(mem_wdata == wpat(m_own, m_base, m_idx), "R6", "write data",
                    mem_wdata, wpat(m_own, m_base, m_idx));
        end
        if (m_busy != 0 && m_dv != 0 && m_we == 0)
            chk(rd_data == m_rdat, "R6", "read data", rd_data, m_rdat);
        if (!rst_n) chk(rd_data == 16'h0, "R10", "read data in reset", rd_data, 0);
        prev_done[0] = bus_done;
        prev_done[1] = cpu_done;
    endtask

    task automatic agents();
        int rv [2];
        int dv [2];
        rv[0] = bus_rdy;  rv[1] = cpu_rdy;
        dv[0] = bus_done; dv[1] = cpu_done;
        for (int s = 0; s < 2; s++) begin
            if (a_req[s] != 0) begin
                if (dv[s] != 0) begin
                    void'(jb[s].pop_front());
                    void'(jl[s].pop_front());
                    void'(jw[s].pop_front());
                    a_req[s] = 0;
                    a_idx[s] = 0;
                end else if (rv[s] != 0) begin
                    a_idx[s]++;
                end
            end else if (jb[s].size() > 0) begin
                a_base[s] = jb[s][0];
                a_len[s]  = jl[s][0];
                a_we[s]   = jw[s][0];
                a_idx[s]  = 0;
                a_req[s]  = 1;
            end
        end
        bus_req   = a_req[0][0];
        bus_base  = 8'(a_base[0]);
        bus_len   = 4'(a_len[0]);
        bus_we    = a_we[0][0];
        bus_wdata = wpat(0, a_base[0], a_idx[0]);
        cpu_req   = a_req[1][0];
        cpu_base  = 8'(a_base[1]);
        cpu_len   = 4'(a_len[1]);
        cpu_we    = a_we[1][0];
        cpu_wdata = wpat(1, a_base[1], a_idx[1]);
    endtask

    task automatic step();
        int pk;
        if (m_busy == 0) begin
            if (bus_req || cpu_req) begin
                pk = (bus_req && cpu_req) ? ((m_last == 0) ? 1 : 0) : (cpu_req ? 1 : 0);
                m_busy = 1;
                m_own  = pk;
                m_base = pk ? int'(cpu_base) : int'(bus_base);
                m_len  = pk ? int'(cpu_len) : int'(bus_len);
                m_we   = pk ? int'(cpu_we) : int'(bus_we);
                m_wait = int'(wait_cfg);
                m_idx  = 0;
                m_t    = 0;
                m_dv   = 0;
            end
        end else if (m_dv != 0) begin
            m_dv = 0;
            m_t  = 0;
            if (m_idx == m_len) begin
                m_busy = 0;
                m_last = m_own;
            end else begin
                m_idx++;
            end
        end else begin
            if (m_t >= m_wait + 3 && mem_ready) begin
                m_dv   = 1;
                m_rdat = mem[8'((m_base + m_idx) % 256)];
            end
            m_t++;
        end
        if (mem_stb && mem_ready && mem_we) mem[mem_addr] = mem_wdata;
    endtask

    task automatic tick();
        @(negedge clk);
        if (mem_stb && prev_stb) stb_cnt++;
        else stb_cnt = 0;
        prev_stb = mem_stb;
        #1;
        compare();
        agents();
        wait_cfg = 3'(wait_next);
        #1;
        if (rst_n) step();
    endtask

    task automatic drain();
        int guard = 0;
        while ((jb[0].size() > 0 || jb[1].size() > 0 || a_req[0] != 0 || a_req[1] != 0 ||
                m_busy != 0) && guard < 4000) begin
            tick();
            guard++;
        end
        tick();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 7 + 3);
        rst_n = 1'b0;
        wait_cfg = '0;
        bus_req = 0; bus_we = 0; bus_base = '0; bus_len = '0; bus_wdata = '0;
        cpu_req = 0; cpu_we = 0; cpu_base = '0; cpu_len = '0; cpu_wdata = '0;
        repeat (3) tick();      // R10 reset state checked in compare
        rst_n = 1'b1;
        repeat (2) tick();
        // R2 tie straight after reset: bus first, CPU stays pending (R8)
        push(0, 8'h10, 3, 1);
        push(1, 8'h20, 1, 1);
        drain();
        // R6 read back both blocks
        push(1, 8'h10, 3, 0);
        drain();
        push(0, 8'h20, 1, 0);
        drain();
        // R2 bus served last, then a tie goes to the CPU
        push(0, 8'h30, 0, 0);
        drain();
        push(0, 8'h31, 1, 0);
        push(1, 8'h32, 1, 0);
        drain();
        // R3 memory stalls beyond the settle phase
        wait_next = 2;
        lat = 9;
        push(1, 8'h10, 3, 0);
        drain();
        lat = 0;
        // R4 settle length changed in mid-transfer
        wait_next = 1;
        push(0, 8'h12, 2, 0);
        repeat (4) tick();
        r4_zone = 1;
        wait_next = 6;
        drain();
        r4_zone = 0;
        push(1, 8'h13, 0, 0);
        drain();
        wait_next = 0;
        // R5 address wrap
        push(0, 8'hFE, 3, 1);
        drain();
        push(1, 8'hFE, 3, 0);
        drain();
        // R7 longest block
        push(1, 8'h40, 15, 1);
        drain();
        push(0, 8'h40, 15, 0);
        drain();
        finished = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule